// File: doc/BRIEF.md
# Shared-Wire Packet Transmitter with Collision Backoff

This block sends one packet at a time onto a single shared serial wire that several stations may drive. After a start request it captures the destination, its own station address and the payload length. It waits until no carrier is sensed on the medium. It then sends a three-byte header, the payload bytes it reads from an external 256-byte transmit buffer, and a closing CRC byte. Each bit is driven for one clock cycle.

While it sends, the block compares the line value it reads back with the bit it drives. A mismatch means another station is driving the wire at the same time. The block then stops the packet and sends a fixed jam sequence. It waits a pseudo-random number of slot times and starts again from the first header byte. A packet ends in one of two ways: a one-cycle done pulse when the send succeeds, or a one-cycle abort pulse after too many failed attempts. A retry counter shows how many attempts have failed so far.

Top module: `csma_tx`

## Requirements
- R1: While `rst_n` is low, `busy`, `tx_en`, `tx_bit`, `done` and `abort` are 0 and `retries` is 0.
- R2: A `start` sampled high while idle captures `dst_addr`, `stn_addr` and `pay_len`, clears `retries` and sets `busy` from the next cycle. While busy, `start` and changes on those three inputs have no effect on the packet being sent.
- R3: After the start, the block defers. In every clock edge that samples `carrier` high it stays deferring with `tx_en` low. The first edge that samples `carrier` low puts the first bit on the wire in the following cycle.
- R4: A packet is sent as these bytes in this order: destination, source, length, the payload bytes, then the CRC byte. Each byte goes out bit 0 first, one bit per cycle, and `tx_en` stays high for (length+4)*8 consecutive cycles. Outside sending and jamming, `tx_bit` is 0.
- R5: Payload byte i (i from 0 to length-1) is taken from `buf_data` while `buf_addr` equals i, in the same cycle. The data is read combinationally. A length of 0 puts the CRC byte straight after the header.
- R6: The CRC byte is CRC-8 with polynomial 0x07 (x^8+x^2+x+1) and initial value 0x00. Each byte is processed most-significant bit first, over the header and payload bytes in wire order.
- R7: A collision is an edge during packet sending where `line_in` differs from `tx_bit`. The cycle after that edge, the packet stops and the first jam bit is on the wire.
- R8: The jam is 4 bytes of 0xAA sent bit 0 first. It lasts exactly 32 cycles with `tx_en` high, and mismatches on the line during the jam are ignored.
- R9: An 8-bit LFSR is reset to 0x5A. It steps on every clock edge out of reset: it shifts up by one, and the new bit 0 is the XOR of bits 7, 5, 4 and 3. At the last jam edge, with n the new retry count, slots = LFSR & (2^min(n,8)-1) using the value before that edge's step. The block then waits slots*64+1 cycles, defers again per R3, and resends the whole packet from the destination byte with the CRC restarted.
- R10: `retries` rises by one at the last edge of each jam. A successful packet gives a one-cycle `done` pulse in the cycle after its last CRC bit, with `busy` low and `retries` back to 0. `done` and `abort` are never high together.
- R11: When the 16th attempt fails, `abort` pulses for one cycle, the block returns to idle, and `retries` holds 16 until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bit time per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to send a packet, taken when idle |
| stn_addr | input | 8 | This station's address, sent as the source byte |
| dst_addr | input | 8 | Destination address |
| pay_len | input | 8 | Payload length in bytes (0..255) |
| buf_addr | output | 8 | Transmit buffer read address |
| buf_data | input | 8 | Transmit buffer read data for `buf_addr` |
| carrier | input | 1 | Carrier sensed on the medium |
| line_in | input | 1 | Value read back from the wire |
| tx_bit | output | 1 | Bit driven onto the wire |
| tx_en | output | 1 | Wire driver enable |
| busy | output | 1 | A packet is in progress |
| done | output | 1 | One-cycle pulse on successful send |
| abort | output | 1 | One-cycle pulse when the retry limit is reached |
| retries | output | 5 | Failed attempts for the current packet |

## Verification
A reference model in the bench predicts every output on every cycle under six input patterns.
- An empty payload shows that the CRC follows the header directly.
- A short payload with carrier held high at first separates a correct defer from a premature send. A start pulse and changed inputs during that packet show that mid-packet requests are ignored.
- A 255-byte payload exercises the full addressing range and the longest CRC run.
- A single collision inside the source byte checks the jam, the backoff length and a restart from the first header byte.
- A line that disagrees on every bit drives the retry count to its limit and must end in one abort pulse.
- A clean packet sent after the abort must leave the retry count cleared.

// File: rtl/csma_tx.sv
module csma_tx #(
  parameter int          JAM_BYTES   = 4,
  parameter logic [7:0]  JAM_PATTERN = 8'hAA,
  parameter int          SLOT_BITS   = 64,
  parameter int          MAX_TRIES   = 16,
  parameter logic [7:0]  LFSR_SEED   = 8'h5A
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start,
  input  logic [7:0]                       stn_addr,
  input  logic [7:0]                       dst_addr,
  input  logic [7:0]                       pay_len,
  output logic [7:0]                       buf_addr,
  input  logic [7:0]                       buf_data,
  input  logic                             carrier,
  input  logic                             line_in,
  output logic                             tx_bit,
  output logic                             tx_en,
  output logic                             busy,
  output logic                             done,
  output logic                             abort,
  output logic [$clog2(MAX_TRIES+1)-1:0]   retries
);
  localparam int RW       = $clog2(MAX_TRIES + 1);
  localparam int JAM_BITS = JAM_BYTES * 8;
  localparam int JW       = $clog2(JAM_BITS);
  localparam int BOW      = $clog2(255 * SLOT_BITS + 1);

  typedef enum logic [2:0] {S_IDLE, S_DEFER, S_SEND, S_JAM, S_WAIT} st_t;

  st_t            st;
  logic [7:0]     hdr_dst, hdr_src, hdr_len, crc, lfsr, cur_byte, mask, slots;
  logic [8:0]     byte_cnt;
  logic [2:0]     bit_cnt;
  logic [JW-1:0]  jam_cnt;
  logic [BOW-1:0] wait_cnt;
  logic [RW-1:0]  next_try;
  logic           last_byte, clash;

  function automatic logic [7:0] crc_step(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c ^ d;
    for (int i = 0; i < 8; i++)
      r = r[7] ? ({r[6:0], 1'b0} ^ 8'h07) : {r[6:0], 1'b0};
    return r;
  endfunction

  assign last_byte = (byte_cnt == ({1'b0, hdr_len} + 9'd3));
  assign buf_addr  = byte_cnt[7:0] - 8'd3;
  assign busy      = (st != S_IDLE);
  assign tx_en     = (st == S_SEND) || (st == S_JAM);
  assign next_try  = retries + RW'(1);

  always_comb begin
    if (byte_cnt == 9'd0)      cur_byte = hdr_dst;
    else if (byte_cnt == 9'd1) cur_byte = hdr_src;
    else if (byte_cnt == 9'd2) cur_byte = hdr_len;
    else if (last_byte)        cur_byte = crc;
    else                       cur_byte = buf_data;
  end

  always_comb begin
    for (int i = 0; i < 8; i++) mask[i] = (int'(next_try) > i);
    slots = lfsr & mask;
  end

  assign tx_bit = (st == S_SEND) ? cur_byte[bit_cnt] :
                  (st == S_JAM)  ? JAM_PATTERN[jam_cnt[2:0]] : 1'b0;
  assign clash  = (st == S_SEND) && (line_in != tx_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      hdr_dst  <= '0;
      hdr_src  <= '0;
      hdr_len  <= '0;
      crc      <= '0;
      byte_cnt <= '0;
      bit_cnt  <= '0;
      jam_cnt  <= '0;
      wait_cnt <= '0;
      retries  <= '0;
      done     <= 1'b0;
      abort    <= 1'b0;
      lfsr     <= LFSR_SEED;
    end else begin
      lfsr  <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      done  <= 1'b0;
      abort <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          hdr_dst <= dst_addr;
          hdr_src <= stn_addr;
          hdr_len <= pay_len;
          retries <= '0;
          st      <= S_DEFER;
        end
        S_DEFER: if (!carrier) begin
          st       <= S_SEND;
          byte_cnt <= '0;
          bit_cnt  <= '0;
          crc      <= '0;
        end
        S_SEND: if (clash) begin
          st      <= S_JAM;
          jam_cnt <= '0;
        end else begin
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            if (last_byte) begin
              st      <= S_IDLE;
              done    <= 1'b1;
              retries <= '0;
            end else begin
              crc      <= crc_step(crc, cur_byte);
              byte_cnt <= byte_cnt + 9'd1;
            end
          end
        end
        S_JAM: if (jam_cnt == JW'(JAM_BITS - 1)) begin
          retries <= next_try;
          if (next_try == RW'(MAX_TRIES)) begin
            abort <= 1'b1;
            st    <= S_IDLE;
          end else begin
            wait_cnt <= BOW'(slots) * BOW'(SLOT_BITS);
            st       <= S_WAIT;
          end
        end else begin
          jam_cnt <= jam_cnt + JW'(1);
        end
        S_WAIT: if (wait_cnt == '0) st <= S_DEFER;
                else wait_cnt <= wait_cnt - BOW'(1);
        default: st <= S_IDLE;
      endcase
    end
  end

  p_defer_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DEFER && carrier) |=> !tx_en);

  p_restart_head_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DEFER && !carrier) |=> (st == S_SEND && byte_cnt == 9'd0 && bit_cnt == 3'd0 && crc == 8'd0));

  p_clash_to_jam_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clash |=> (st == S_JAM && jam_cnt == '0));

  p_done_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (retries == '0 && !busy));

  p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && abort));

  p_abort_limit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> (retries == RW'(MAX_TRIES) && !busy));

  p_retry_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    retries <= RW'(MAX_TRIES));
endmodule

// File: tb/csma_tx_bench.sv
`timescale 1ns/1ps
module csma_tx_bench;
  localparam int         SLOT  = 64;
  localparam int         TRIES = 16;
  localparam logic [7:0] SEED  = 8'h5A;

  logic       clk = 1'b0, rst_n = 1'b0, start = 1'b0, carrier = 1'b0, clash = 1'b0;
  logic [7:0] stn = 8'h00, dst = 8'h00, len = 8'h00;
  logic [7:0] baddr, bdata;
  logic       txb, txe, busy, done, abort, line;
  logic [4:0] retries;
  logic [7:0] mem [256];

  assign bdata = mem[baddr];
  assign line  = txb ^ clash;
  always #2 clk = ~clk;

  csma_tx u_csma_tx (
    .clk(clk), .rst_n(rst_n), .start(start), .stn_addr(stn), .dst_addr(dst),
    .pay_len(len), .buf_addr(baddr), .buf_data(bdata), .carrier(carrier),
    .line_in(line), .tx_bit(txb), .tx_en(txe), .busy(busy), .done(done),
    .abort(abort), .retries(retries));

  int nchk = 0, nfail = 0, cyc = 0;
  int ndone = 0, nabort = 0, gap = 0, maxr = 0;
  bit cap[$];

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] crc8(logic [7:0] c, logic [7:0] d);
    logic [7:0] r = c ^ d;
    for (int i = 0; i < 8; i++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
    return r;
  endfunction

  // Reference model: 0 idle, 1 defer, 2 send, 3 jam, 4 backoff
  int ms = 0, mk = 0, mb = 0, mjc = 0, mbo = 0, mr = 0, jam_pos = 0, last_slots = 0;
  logic [7:0] mcrc = 0, ml = SEED, md = 0, msrc = 0, mlen = 0;
  bit mdone = 0, mabort = 0;

  function automatic logic [7:0] mbyte();
    if (mk == 0) return md;
    if (mk == 1) return msrc;
    if (mk == 2) return mlen;
    if (mk < int'(mlen) + 3) return mem[mk - 3];
    return mcrc;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ms = 0; mr = 0; mdone = 0; mabort = 0; ml = SEED;
    end else begin
      mdone = 0; mabort = 0;
      case (ms)
        0: if (start) begin md = dst; msrc = stn; mlen = len; mr = 0; ms = 1; end
        1: if (!carrier) begin ms = 2; mk = 0; mb = 0; mcrc = 0; end
        2: if (clash) begin ms = 3; mjc = 0; jam_pos = cap.size(); end
           else if (mb == 7) begin
             if (mk == int'(mlen) + 3) begin ms = 0; mdone = 1; mr = 0; end
             else begin mcrc = crc8(mcrc, mbyte()); mk++; mb = 0; end
           end else mb++;
        3: if (mjc == 31) begin
             mr++;
             if (mr == TRIES) begin mabort = 1; ms = 0; end
             else begin
               last_slots = int'(ml) & ((1 << (mr > 8 ? 8 : mr)) - 1);
               mbo = last_slots * SLOT; ms = 4;
             end
           end else mjc++;
        4: if (mbo == 0) ms = 1; else mbo--;
        default: ms = 0;
      endcase
      ml = {ml[6:0], ml[7] ^ ml[5] ^ ml[4] ^ ml[3]};
    end
  end

  always @(negedge clk) begin
    logic [7:0] eb;
    int ebit;
    if (rst_n) begin
      if (txe) cap.push_back(txb);
      if (busy && !txe) gap++;
      if (done) ndone++;
      if (abort) nabort++;
      if (int'(retries) > maxr) maxr = int'(retries);
      eb = mbyte();
      ebit = (ms == 2) ? int'(eb[mb[2:0]]) : (ms == 3) ? int'((8'hAA >> (mjc % 8)) & 8'h01) : 0;
      chk("R4 tx_bit", int'(txb), ebit);
      chk("R3 tx_en", int'(txe), int'(ms == 2 || ms == 3));
      chk("R2 busy", int'(busy), int'(ms != 0));
      chk("R10 done", int'(done), int'(mdone));
      chk("R11 abort", int'(abort), int'(mabort));
      chk("R10 retries", int'(retries), mr);
      if (ms == 2 && mk >= 3 && mk < int'(mlen) + 3) chk("R5 buf_addr", int'(baddr), mk - 3);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 200000) begin
      nfail++;
      $display("FAIL watchdog expired actual=%0d expected=<200000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  task automatic kick(logic [7:0] d, logic [7:0] s, logic [7:0] l);
    @(negedge clk);
    cap.delete(); gap = 0; maxr = 0;
    dst = d; stn = s; len = l; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    while (ms != 0) @(negedge clk);
  endtask

  function automatic logic [7:0] cap_byte(int pos);
    logic [7:0] v = 8'h00;
    for (int b = 0; b < 8; b++) if (pos + b < cap.size()) v[b] = cap[pos + b];
    return v;
  endfunction

  task automatic check_frame(logic [7:0] d, logic [7:0] s, logic [7:0] l, int off);
    logic [7:0] c = 8'h00;
    logic [7:0] exp;
    chk("R4 frame length", cap.size() - off, (int'(l) + 4) * 8);
    for (int i = 0; i < int'(l) + 4; i++) begin
      if (i == 0) exp = d;
      else if (i == 1) exp = s;
      else if (i == 2) exp = l;
      else if (i < int'(l) + 3) exp = mem[i - 3];
      else exp = c;
      if (i < int'(l) + 3) c = crc8(c, exp);
      if (i < 3) chk("R4 header byte", int'(cap_byte(off + 8 * i)), int'(exp));
      else if (i < int'(l) + 3) chk("R5 payload byte", int'(cap_byte(off + 8 * i)), int'(exp));
      else chk("R6 crc byte", int'(cap_byte(off + 8 * i)), int'(exp));
    end
  endtask

  initial begin
    int d0;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
    repeat (3) @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 tx_en", int'(txe), 0);
    chk("R1 tx_bit", int'(txb), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 abort", int'(abort), 0);
    chk("R1 retries", int'(retries), 0);
    rst_n = 1'b1;

    // empty payload
    kick(8'h3C, 8'h81, 8'd0);
    wait_idle();
    check_frame(8'h3C, 8'h81, 8'd0, 0);

    // short payload, carrier first busy, mid-packet start ignored
    carrier = 1'b1;
    kick(8'hC5, 8'h0F, 8'd6);
    repeat (20) @(negedge clk);
    chk("R3 no send under carrier", cap.size(), 0);
    carrier = 1'b0;
    while (!(ms == 2 && mk == 4)) @(negedge clk);
    d0 = ndone;
    dst = 8'hEE; stn = 8'h44; len = 8'd9; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    @(negedge clk);
    chk("R2 start while busy ignored", int'(busy), 0);
    chk("R10 single done", ndone - d0, 1);
    check_frame(8'hC5, 8'h0F, 8'd6, 0);

    // full payload
    kick(8'h01, 8'hFE, 8'd255);
    wait_idle();
    check_frame(8'h01, 8'hFE, 8'd255, 0);

    // one collision inside the source byte
    kick(8'h11, 8'h22, 8'd3);
    while (!(ms == 2 && mk == 1 && mb == 3)) @(negedge clk);
    clash = 1'b1;
    @(negedge clk);
    clash = 1'b0;
    wait_idle();
    @(negedge clk);
    chk("R7 jam follows collision", int'(cap_byte(jam_pos)), 8'hAA);
    for (int j = 1; j < 4; j++) chk("R8 jam byte", int'(cap_byte(jam_pos + 8 * j)), 8'hAA);
    chk("R8 jam length", cap.size(), jam_pos + 32 + 7 * 8);
    chk("R9 backoff gap", gap, 1 + last_slots * SLOT + 2);
    chk("R10 retries peak", maxr, 1);
    chk("R10 retries cleared", int'(retries), 0);
    check_frame(8'h11, 8'h22, 8'd3, cap.size() - 7 * 8);

    // collision on every attempt
    d0 = nabort;
    clash = 1'b1;
    kick(8'h55, 8'h66, 8'd2);
    wait_idle();
    clash = 1'b0;
    @(negedge clk);
    chk("R11 one abort", nabort - d0, 1);
    chk("R11 retries hold", int'(retries), TRIES);
    chk("R11 idle after abort", int'(busy), 0);
    chk("R8 jam per attempt", cap.size(), TRIES * 33);

    // clean packet after abort
    kick(8'h77, 8'h12, 8'd1);
    wait_idle();
    @(negedge clk);
    chk("R10 retries after success", int'(retries), 0);
    check_frame(8'h77, 8'h12, 8'd1, 0);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule